// File: doc/BRIEF.md
# Segmented Memory Map Translator

This block turns the addresses a processor core issues into physical targets. Data accesses use a 16-bit address. Instruction fetches use an 18-bit byte address. For each address the block reports four things:

- which memory holds it: on-chip data RAM, on-chip instruction RAM, or a unified memory segment;
- the unified segment number;
- the byte offset inside the chosen memory;
- whether the access is a bus error.

Both translations are purely combinational. They are computed from the address and three 16-bit map registers:

- a data map, which steers a 16 KB data window;
- two fetch maps, one chosen by bit 17 of the fetch address.

A simple register port writes the maps. A presence mask input marks which unified segments exist, so that a fetch into an absent segment can be flagged.

Top module: `addr_map_xlate`

## Requirements
- R1: A data address below 0x8000 gives target code 0 (data RAM), offset equal to the address, segment 0 and no bus error.
- R2: A data address of 0xC000 or above gives target code 0 with offset equal to the address. The bus error is raised unless the address lies in 0xFF00..0xFF0F.
- R3: A data address in 0x8000..0xBFFF with data-map bit 12 set gives target code 1 (instruction RAM). The offset is data-map[3:0]*0x4000 + (address - 0x8000), with no bus error.
- R4: A data address in 0x8000..0xBFFF with data-map bit 12 clear gives target code 2 (unified). The segment is data-map[9:3] and the offset is data-map[2:0]*0x4000 + (address - 0x8000), with no bus error.
- R5: A fetch translation uses fetch map 1 when fetch-address bit 17 is set, and fetch map 0 when it is clear.
- R6: When the selected fetch map has bit 12 set, the fetch gives target code 1, offset equal to the full 18-bit fetch address, segment 0 and no bus error.
- R7: When the selected fetch map has bit 12 clear, the fetch gives target code 2, segment = map[7:0] and offset = fetch-address[16:0]. The bus error is raised exactly when the presence-mask bit for that segment is 0.
- R8: After reset the data map is 0x0000, fetch map 0 is 0x0000 and fetch map 1 is 0x007F.
- R9: A write with select 0 (data map), 1 (fetch map 0) or 2 (fetch map 1) is seen by translations from the cycle after the capturing clock edge, not before. A write with select 3 changes no map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Map register write strobe |
| cfg_sel | input | 2 | Map select: 0 data, 1 fetch map 0, 2 fetch map 1, 3 none |
| cfg_wdata | input | 16 | Map write value |
| seg_present | input | 256 | One bit per unified segment, 1 = present |
| dat_addr | input | 16 | Data address |
| dat_tgt | output | 2 | Data target code (0 data RAM, 1 instruction RAM, 2 unified) |
| dat_seg | output | 8 | Data unified segment |
| dat_off | output | 18 | Data byte offset |
| dat_berr | output | 1 | Data bus error |
| ftc_addr | input | 18 | Fetch byte address |
| ftc_tgt | output | 2 | Fetch target code |
| ftc_seg | output | 8 | Fetch unified segment |
| ftc_off | output | 18 | Fetch byte offset |
| ftc_berr | output | 1 | Fetch bus error |

## Verification
Both translations settle in the same cycle as their address, so the bench drives addresses on the falling edge and samples a nanosecond later, with no clock edge between. A map write is due one edge later. The bench first checks the old translation while the strobe is still high before the edge, then checks the new translation just after that edge. The bench's model maps are updated only at that edge, which keeps random traffic aligned with the same one-cycle latency.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    parameter int MAP_W  = 16;
    parameter int DA_W   = 16;
    parameter int FA_W   = 18;
    parameter int SEG_W  = 8;
    parameter int OFF_W  = 18;
    localparam int NSEG  = 1 << SEG_W;
    localparam int WIN_W = 14;          // 16 KB data window

    typedef enum logic [1:0] {
        TGT_DRAM = 2'd0,
        TGT_IRAM = 2'd1,
        TGT_UMEM = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [SEG_W-1:0] seg;
        logic [OFF_W-1:0] off;
        logic             berr;
    } xres_t;

    typedef struct packed {
        logic [MAP_W-1:0] dmap;
        logic [MAP_W-1:0] imap0;
        logic [MAP_W-1:0] imap1;
    } maps_t;

    localparam logic [MAP_W-1:0] DMAP_RST  = 16'h0000;
    localparam logic [MAP_W-1:0] IMAP0_RST = 16'h0000;
    localparam logic [MAP_W-1:0] IMAP1_RST = 16'h007F;
endpackage

// File: rtl/xlate_map_regs.sv
module xlate_map_regs
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [MAP_W-1:0] wdata,
    output maps_t            maps
);
    maps_t maps_d, maps_q;

    always_comb begin
        maps_d = maps_q;
        if (we) begin
            case (sel)
                2'd0:    maps_d.dmap  = wdata;
                2'd1:    maps_d.imap0 = wdata;
                2'd2:    maps_d.imap1 = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            maps_q.dmap  <= DMAP_RST;
            maps_q.imap0 <= IMAP0_RST;
            maps_q.imap1 <= IMAP1_RST;
        end else begin
            maps_q <= maps_d;
        end
    end

    assign maps = maps_q;

    AST_DMAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == 2'd0) |=> (maps.dmap == $past(wdata)));                       // R9
    AST_SEL3_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == 2'd3) |=> $stable(maps));                                     // R9
endmodule

// File: rtl/xlate_data.sv
module xlate_data
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DA_W-1:0]  addr,
    input  logic [MAP_W-1:0] dmap,
    output xres_t            res
);
    localparam int LO_W = OFF_W - WIN_W;   // width of the window bank field

    always_comb begin
        res      = '0;
        res.tgt  = TGT_DRAM;
        res.off  = OFF_W'(addr);
        if (addr[DA_W-1 -: 2] == 2'b11) begin
            res.berr = (addr[DA_W-1:4] != 12'hFF0);
        end else if (addr[DA_W-1]) begin
            if (dmap[12]) begin
                res.tgt = TGT_IRAM;
                res.off = {dmap[LO_W-1:0], addr[WIN_W-1:0]};
            end else begin
                res.tgt = TGT_UMEM;
                res.seg = SEG_W'(dmap[9:3]);
                res.off = OFF_W'({dmap[2:0], addr[WIN_W-1:0]});
            end
        end
    end

    AST_LOW_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < 16'h8000) |-> (res.tgt == TGT_DRAM && !res.berr && res.off == OFF_W'(addr))); // R1
    AST_IO_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= 16'hC000) |-> (res.tgt == TGT_DRAM && res.off == OFF_W'(addr)));      // R2
    AST_WIN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= 16'h8000 && addr < 16'hC000) |-> !res.berr);                          // R4
    AST_WIN_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= 16'h8000 && addr < 16'hC000) |-> (res.off[WIN_W-1:0] == addr[WIN_W-1:0])); // R3
endmodule

// File: rtl/xlate_fetch.sv
module xlate_fetch
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FA_W-1:0]  addr,
    input  logic [MAP_W-1:0] imap0,
    input  logic [MAP_W-1:0] imap1,
    input  logic [NSEG-1:0]  present,
    output xres_t            res
);
    logic [MAP_W-1:0] map_sel;

    assign map_sel = addr[FA_W-1] ? imap1 : imap0;

    always_comb begin
        res     = '0;
        res.tgt = TGT_IRAM;
        res.off = OFF_W'(addr);
        if (!map_sel[12]) begin
            res.tgt  = TGT_UMEM;
            res.seg  = map_sel[SEG_W-1:0];
            res.off  = OFF_W'(addr[FA_W-2:0]);
            res.berr = !present[map_sel[SEG_W-1:0]];
        end
    end

    AST_FETCH_IRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (res.tgt == TGT_IRAM) |-> (res.off == OFF_W'(addr) && !res.berr));          // R6
    AST_FETCH_UMEM_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (res.tgt == TGT_UMEM) |-> (res.berr == !present[res.seg]));                  // R7
    AST_FETCH_UMEM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (res.tgt == TGT_UMEM) |-> (res.off[OFF_W-1] == 1'b0));                       // R7
endmodule

// File: rtl/addr_map_xlate.sv
module addr_map_xlate
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [15:0]      cfg_wdata,
    input  logic [255:0]     seg_present,
    input  logic [15:0]      dat_addr,
    output logic [1:0]       dat_tgt,
    output logic [7:0]       dat_seg,
    output logic [17:0]      dat_off,
    output logic             dat_berr,
    input  logic [17:0]      ftc_addr,
    output logic [1:0]       ftc_tgt,
    output logic [7:0]       ftc_seg,
    output logic [17:0]      ftc_off,
    output logic             ftc_berr
);
    maps_t maps;
    xres_t d_res, f_res;

    xlate_map_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .maps  (maps)
    );

    xlate_data u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (dat_addr),
        .dmap  (maps.dmap),
        .res   (d_res)
    );

    xlate_fetch u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (ftc_addr),
        .imap0   (maps.imap0),
        .imap1   (maps.imap1),
        .present (seg_present),
        .res     (f_res)
    );

    assign dat_tgt  = d_res.tgt;
    assign dat_seg  = d_res.seg;
    assign dat_off  = d_res.off;
    assign dat_berr = d_res.berr;
    assign ftc_tgt  = f_res.tgt;
    assign ftc_seg  = f_res.seg;
    assign ftc_off  = f_res.off;
    assign ftc_berr = f_res.berr;
endmodule

// File: tb/addr_map_xlate_tb.sv
`timescale 1ns/1ps
module addr_map_xlate_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_sel = '0;
    logic [15:0]  cfg_wdata = '0;
    logic [255:0] seg_present = '1;
    logic [15:0]  dat_addr = '0;
    logic [1:0]   dat_tgt;
    logic [7:0]   dat_seg;
    logic [17:0]  dat_off;
    logic         dat_berr;
    logic [17:0]  ftc_addr = '0;
    logic [1:0]   ftc_tgt;
    logic [7:0]   ftc_seg;
    logic [17:0]  ftc_off;
    logic         ftc_berr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_dmap, m_imap0, m_imap1;

    always #5 clk = ~clk;

    addr_map_xlate u_dut (.*);

    // expected value packed as {tgt[1:0], seg[7:0], off[17:0], berr}
    function automatic logic [28:0] exp_dat(input logic [15:0] a, input logic [15:0] dm);
        logic [1:0] t; logic [7:0] s; logic [17:0] o; logic e;
        t = 2'd0; s = 8'd0; o = {2'b00, a}; e = 1'b0;
        if (a >= 16'hC000) begin
            e = !(a >= 16'hFF00 && a <= 16'hFF0F);
        end else if (a >= 16'h8000) begin
            if (dm[12]) begin
                t = 2'd1;
                o = 18'(dm[3:0]) * 18'h4000 + 18'(a - 16'h8000);
            end else begin
                t = 2'd2;
                s = {1'b0, dm[9:3]};
                o = 18'(dm[2:0]) * 18'h4000 + 18'(a - 16'h8000);
            end
        end
        return {t, s, o, e};
    endfunction

    function automatic logic [28:0] exp_ftc(input logic [17:0] a, input logic [15:0] m0,
                                             input logic [15:0] m1, input logic [255:0] pr);
        logic [15:0] m;
        m = (a >= 18'h20000) ? m1 : m0;
        if (m[12]) return {2'd1, 8'd0, a, 1'b0};
        return {2'd2, m[7:0], {1'b0, a[16:0]}, !pr[m[7:0]]};
    endfunction

    task automatic check(input string req, input logic [28:0] got, input logic [28:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic chk_dat(input string req, input logic [15:0] a);
        @(negedge clk); dat_addr = a; #1;
        check(req, {dat_tgt, dat_seg, dat_off, dat_berr}, exp_dat(a, m_dmap));
    endtask

    task automatic chk_ftc(input string req, input logic [17:0] a);
        @(negedge clk); ftc_addr = a; #1;
        check(req, {ftc_tgt, ftc_seg, ftc_off, ftc_berr}, exp_ftc(a, m_imap0, m_imap1, seg_present));
    endtask

    task automatic model_wr(input logic [1:0] s, input logic [15:0] v);
        case (s)
            2'd0: m_dmap  = v;
            2'd1: m_imap0 = v;
            2'd2: m_imap1 = v;
            default: ;
        endcase
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(posedge clk); #1; cfg_we = 1'b0;
        model_wr(s, v);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_dmap = 16'h0000; m_imap0 = 16'h0000; m_imap1 = 16'h007F;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8 reset state seen through translations
        chk_dat("R8", 16'h8123);
        chk_ftc("R8", 18'h20010);
        chk_ftc("R8", 18'h00040);

        // R1 / R2 directed corners
        chk_dat("R1", 16'h0000);
        chk_dat("R1", 16'h7FFF);
        chk_dat("R2", 16'hFF00);
        chk_dat("R2", 16'hFF0F);
        chk_dat("R2", 16'hFF10);
        chk_dat("R2", 16'hC000);
        chk_dat("R2", 16'hFEFF);

        // R3 window into instruction RAM
        wr(2'd0, 16'h100F);
        chk_dat("R3", 16'h8000);
        chk_dat("R3", 16'hBFFF);
        // R4 window into unified memory
        wr(2'd0, 16'h03FF);
        chk_dat("R4", 16'h8000);
        chk_dat("R4", 16'hBFFF);

        // R5 / R6 / R7 fetch map selection
        wr(2'd1, 16'h1000);
        wr(2'd2, 16'h0045);
        chk_ftc("R6", 18'h1FFFC);
        chk_ftc("R5", 18'h3FFFC);
        seg_present[8'h45] = 1'b0;
        chk_ftc("R7", 18'h20004);
        seg_present[8'h45] = 1'b1;
        chk_ftc("R7", 18'h20004);

        // R9 write latency: old value before the edge, new after
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'h1003; dat_addr = 16'h9000; #1;
        check("R9", {dat_tgt, dat_seg, dat_off, dat_berr}, exp_dat(16'h9000, m_dmap));
        @(posedge clk); #1; cfg_we = 1'b0; model_wr(2'd0, 16'h1003);
        check("R9", {dat_tgt, dat_seg, dat_off, dat_berr}, exp_dat(16'h9000, m_dmap));
        // R9 select 3 changes nothing
        wr(2'd3, 16'h0000);
        chk_dat("R9", 16'h9000);
        chk_ftc("R9", 18'h00100);
        chk_ftc("R9", 18'h20100);

        // random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 3) == 0)
                wr(2'($urandom_range(0, 3)), 16'($urandom));
            for (int k = 0; k < 8; k++) seg_present[k*32 +: 32] = $urandom;
            chk_dat("R1-4", 16'($urandom));
            chk_ftc("R5-7", 18'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule